// File: doc/BRIEF.md
# Dynamic Voltage Ramp Controller

This block moves the output voltage codes of several step-down regulator channels toward programmed targets at a controlled rate. One code LSB is 10 mV. Each channel holds two setpoints, A and B, and a select bit that chooses which one is the live target. The block drives one code per channel to that channel's DAC. It also drives one low-power (pulse-frequency) mode request per channel, a combined "slewing" flag and a one-cycle "all ready" event.

Software programs the block through a single-cycle write strobe with an address and a data byte. A new voltage can be staged in the unselected setpoint and then released on several channels in the same cycle with one write to the shared select register. A free-running prescaler sets the step pace. It gives a 0.5 µs tick, and each channel makes one 10 mV step every 1, 2, 4 or 8 ticks. Downward ramps that aim below the 0.7 V floor stop stepping at the floor code. The channel then applies the final target directly, and the mode request forces low-power mode while the code is below the floor.

Top module: `dvr_ramp_ctrl`

## Requirements
- R1: After reset every code equals its parameter default, both setpoints hold that default, setpoint A is selected, all channels are enabled, mode is automatic (00) and slew field is 00; slewing and all_ready are 0.
- R2: While an enabled channel ramps, its code changes by exactly one LSB per step toward the active target.
- R3: A tick occurs every TICK_DIV clocks; the channel control register slew field (bits [3:2]) sets 8, 4, 2 or 1 ticks per step for values 00, 01, 10, 11.
- R4: A write to the selected setpoint of an enabled channel (setpoint A at address i, setpoint B at address N_CH+i) makes slewing high in the next cycle, and the code ramps to the new value.
- R5: A write to the unselected setpoint leaves the code unchanged. A write to the select register (address 2*N_CH, bit i = 1 selects B for channel i) starts ramps on every channel whose selection changed.
- R6: slewing is the OR of all channels' ramp activity; all_ready is high for exactly one cycle, the cycle after slewing falls.
- R7: A downward ramp to a target below FLOOR_CODE steps only down to FLOOR_CODE, and the code becomes the target one cycle later.
- R8: pfm_req[i] is 1 when the code is below FLOOR_CODE, or the control register mode field (bits [1:0]) is 10, or the field is 00 or 11 with load_hi[i] low; with field 01 and code at or above the floor it is 0.
- R9: When its enable bit (register 2*N_CH+1, bit i) is 0, a channel holds its code and does not slew. When the bit is set again, the code takes the active target in the second cycle after the write, with no ramp.
- R10: If the target changes during a ramp, the channel turns toward the new target from its current code and never passes either target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | 8 | Register write data |
| load_hi | input | N_CH | Per-channel heavy-load indication used in automatic mode |
| vcode | output | N_CH*8 | Voltage code per channel, channel i in bits [8i+7:8i] |
| pfm_req | output | N_CH | Per-channel low-power mode request |
| slewing | output | 1 | High while any channel ramps |
| all_ready | output | 1 | One-cycle event when the last ramp ends |

## Verification
The assertions assume that reset is held for at least two clock edges, so codes already equal their targets before the first checked cycle. They also assume that N_CH is no larger than the data width. Writes are expected only to mapped addresses, and the bench only writes to mapped addresses. It holds reset for four cycles and keeps targets inside the 8-bit code range. Stimulus changes only on falling edges, so every write and load indication is stable at the rising edge that consumes it.

// File: rtl/dvr_pkg.sv
package dvr_pkg;

    localparam int CODE_W = 8;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [1:0] {
        MODE_AUTO     = 2'b00,
        MODE_PWM      = 2'b01,
        MODE_PFM      = 2'b10,
        MODE_AUTO_ALT = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        SLEW_8T = 2'b00,
        SLEW_4T = 2'b01,
        SLEW_2T = 2'b10,
        SLEW_1T = 2'b11
    } slew_e;

    typedef struct packed {
        code_t set_a;
        code_t set_b;
        logic  sel;
        logic  en;
        mode_e mode;
        slew_e slew;
    } ch_cfg_t;

    typedef struct packed {
        code_t code;
        logic  slewing;
        logic  pfm;
    } ch_stat_t;

    function automatic logic [3:0] ticks_per_step(slew_e s);
        case (s)
            SLEW_8T: return 4'd8;
            SLEW_4T: return 4'd4;
            SLEW_2T: return 4'd2;
            default: return 4'd1;
        endcase
    endfunction

    function automatic logic is_auto(mode_e m);
        return (m == MODE_AUTO) || (m == MODE_AUTO_ALT);
    endfunction

endpackage

// File: rtl/dvr_tick_gen.sv
module dvr_tick_gen #(
    parameter int TICK_DIV = 50
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CNT_W = $clog2(TICK_DIV + 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick_o = (cnt_q == CNT_W'(TICK_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + CNT_W'(1);
    end

    generate
        if (TICK_DIV > 1) begin : g_gap
            assert_tick_gap_R3: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o)
                else $error("tick repeated on consecutive cycles");
        end
    endgenerate

endmodule

// File: rtl/dvr_regs.sv
module dvr_regs
    import dvr_pkg::*;
#(
    parameter int                       N_CH      = 4,
    parameter int                       ADDR_W    = 4,
    parameter logic [N_CH*CODE_W-1:0]   DEF_CODES = '0,
    parameter logic [N_CH-1:0]          EN_RST    = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CODE_W-1:0] wr_data,
    output ch_cfg_t           cfg_o [N_CH]
);
    localparam int B_BASE   = N_CH;
    localparam int SEL_ADDR = 2 * N_CH;
    localparam int EN_ADDR  = 2 * N_CH + 1;
    localparam int CTL_BASE = 2 * N_CH + 2;

    ch_cfg_t cfg_q [N_CH];
    int      addr;

    assign addr = int'(wr_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_CH; i++) begin
                cfg_q[i].set_a <= DEF_CODES[i*CODE_W +: CODE_W];
                cfg_q[i].set_b <= DEF_CODES[i*CODE_W +: CODE_W];
                cfg_q[i].sel   <= 1'b0;
                cfg_q[i].en    <= EN_RST[i];
                cfg_q[i].mode  <= MODE_AUTO;
                cfg_q[i].slew  <= SLEW_8T;
            end
        end else if (wr_en) begin
            for (int i = 0; i < N_CH; i++) begin
                if (addr == i)            cfg_q[i].set_a <= wr_data;
                if (addr == B_BASE + i)   cfg_q[i].set_b <= wr_data;
                if (addr == SEL_ADDR)     cfg_q[i].sel   <= wr_data[i];
                if (addr == EN_ADDR)      cfg_q[i].en    <= wr_data[i];
                if (addr == CTL_BASE + i) begin
                    cfg_q[i].mode <= mode_e'(wr_data[1:0]);
                    cfg_q[i].slew <= slew_e'(wr_data[3:2]);
                end
            end
        end
    end

    assign cfg_o = cfg_q;

    initial begin
        assert_ch_fit_R5: assert (N_CH <= CODE_W)
            else $error("select register narrower than channel count");
    end

endmodule

// File: rtl/dvr_chan.sv
module dvr_chan
    import dvr_pkg::*;
#(
    parameter int    FLOOR_CODE = 70,
    parameter code_t RST_CODE   = '0,
    parameter logic  RST_EN     = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  ch_cfg_t  cfg,
    input  logic     load_hi,
    output ch_stat_t stat_o
);
    localparam code_t FLOOR = code_t'(FLOOR_CODE);

    code_t      code_q;
    code_t      target;
    logic       en_prev_q;
    logic [3:0] sub_q;
    logic [3:0] lim;
    logic       en_rise;
    logic       active;
    logic       going_down;
    logic       floor_jump;
    logic       step_now;

    always_comb begin
        target     = cfg.sel ? cfg.set_b : cfg.set_a;
        lim        = ticks_per_step(cfg.slew);
        en_rise    = cfg.en & ~en_prev_q;
        active     = cfg.en & en_prev_q & (code_q != target);
        going_down = code_q > target;
        floor_jump = active & going_down & (target < FLOOR) & (code_q <= FLOOR);
        step_now   = active & tick & (sub_q == lim - 4'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q    <= RST_CODE;
            en_prev_q <= RST_EN;
        end else begin
            en_prev_q <= cfg.en;
            if (en_rise)         code_q <= target;
            else if (floor_jump) code_q <= target;
            else if (step_now)   code_q <= going_down ? code_q - code_t'(1)
                                                      : code_q + code_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !active || floor_jump) sub_q <= '0;
        else if (tick)                    sub_q <= (sub_q == lim - 4'd1) ? 4'd0 : sub_q + 4'd1;
    end

    always_comb begin
        stat_o.code    = code_q;
        stat_o.slewing = active;
        stat_o.pfm     = (code_q < FLOOR) | (cfg.mode == MODE_PFM)
                       | (is_auto(cfg.mode) & ~load_hi);
    end

    assert_one_lsb_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg.en) && $past(en_prev_q) && (code_q != $past(code_q))) |->
        ((code_q == $past(code_q) + code_t'(1)) ||
         (code_q == $past(code_q) - code_t'(1)) ||
         (($past(code_q) <= FLOOR) && (code_q < FLOOR))))
        else $error("code moved by more than one LSB");

    assert_hold_off_R9: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |=> $stable(code_q))
        else $error("disabled channel changed code");

    assert_no_pass_up_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && en_prev_q && (code_q < target)) |=> (code_q <= $past(target)))
        else $error("upward ramp passed target");

    assert_no_pass_down_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && en_prev_q && (code_q > target)) |=> (code_q >= $past(target)))
        else $error("downward ramp passed target");

endmodule

// File: rtl/dvr_ramp_ctrl.sv
module dvr_ramp_ctrl
    import dvr_pkg::*;
#(
    parameter int                     N_CH       = 4,
    parameter int                     TICK_DIV   = 50,
    parameter int                     FLOOR_CODE = 70,
    parameter int                     ADDR_W     = 4,
    parameter logic [N_CH*CODE_W-1:0] DEF_CODES  = {8'd120, 8'd80, 8'd90, 8'd100},
    parameter logic [N_CH-1:0]        EN_RST     = '1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [CODE_W-1:0]      wr_data,
    input  logic [N_CH-1:0]        load_hi,
    output logic [N_CH*CODE_W-1:0] vcode,
    output logic [N_CH-1:0]        pfm_req,
    output logic                   slewing,
    output logic                   all_ready
);
    logic            tick;
    ch_cfg_t         cfg  [N_CH];
    ch_stat_t        stat [N_CH];
    logic [N_CH-1:0] ch_slew;
    logic            any_q;

    dvr_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    dvr_regs #(
        .N_CH      (N_CH),
        .ADDR_W    (ADDR_W),
        .DEF_CODES (DEF_CODES),
        .EN_RST    (EN_RST)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg_o   (cfg)
    );

    generate
        for (genvar g = 0; g < N_CH; g++) begin : g_ch
            dvr_chan #(
                .FLOOR_CODE (FLOOR_CODE),
                .RST_CODE   (DEF_CODES[g*CODE_W +: CODE_W]),
                .RST_EN     (EN_RST[g])
            ) u_chan (
                .clk     (clk),
                .rst     (rst),
                .tick    (tick),
                .cfg     (cfg[g]),
                .load_hi (load_hi[g]),
                .stat_o  (stat[g])
            );
            assign vcode[g*CODE_W +: CODE_W] = stat[g].code;
            assign pfm_req[g]                = stat[g].pfm;
            assign ch_slew[g]                = stat[g].slewing;
        end
    endgenerate

    assign slewing   = |ch_slew;
    assign all_ready = any_q & ~slewing;

    always_ff @(posedge clk) begin
        if (rst) any_q <= 1'b0;
        else     any_q <= slewing;
    end

    assert_ready_single_R6: assert property (@(posedge clk) disable iff (rst)
        all_ready |=> !all_ready)
        else $error("ready event longer than one cycle");

    assert_ready_after_ramp_R6: assert property (@(posedge clk) disable iff (rst)
        all_ready |-> (!slewing && $past(slewing)))
        else $error("ready event without a finished ramp");

endmodule

// File: tb/dvr_ramp_ctrl_bench.sv
module dvr_ramp_ctrl_bench;

    localparam int N     = 4;
    localparam int DIV   = 4;
    localparam int FLOOR = 70;
    localparam int AW    = 4;
    localparam logic [N*8-1:0] DEFS = {8'd120, 8'd80, 8'd90, 8'd100};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [N-1:0]  load_hi = '1;
    logic [N*8-1:0] vcode;
    logic [N-1:0]  pfm_req;
    logic          slewing;
    logic          all_ready;

    always #5 clk = ~clk;

    dvr_ramp_ctrl #(
        .N_CH       (N),
        .TICK_DIV   (DIV),
        .FLOOR_CODE (FLOOR),
        .ADDR_W     (AW),
        .DEF_CODES  (DEFS),
        .EN_RST     ('1)
    ) u_dvr_ramp_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .load_hi   (load_hi),
        .vcode     (vcode),
        .pfm_req   (pfm_req),
        .slewing   (slewing),
        .all_ready (all_ready)
    );

    int checks = 0;
    int errors = 0;
    int rdy_cnt = 0;

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int code_of(int ch);
        return int'(vcode[ch*8 +: 8]);
    endfunction

    // ---------------- reference model ----------------
    int m_a[N], m_b[N], m_sel[N], m_en[N], m_enp[N];
    int m_mode[N], m_slew[N], m_code[N], m_sc[N];
    int m_pre;
    bit m_anyp;

    function automatic int m_tgt(int i);
        return (m_sel[i] != 0) ? m_b[i] : m_a[i];
    endfunction

    function automatic bit m_slw(int i);
        return (m_en[i] != 0) && (m_enp[i] != 0) && (m_code[i] != m_tgt(i));
    endfunction

    function automatic bit m_any();
        bit r = 0;
        for (int i = 0; i < N; i++) r |= m_slw(i);
        return r;
    endfunction

    always @(posedge clk) begin : model
        int nc[N];
        int ns[N];
        int lim;
        int t;
        bit tick;
        bit jump;
        int a;
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_a[i] = int'(DEFS[i*8 +: 8]);
                m_b[i] = m_a[i];
                m_code[i] = m_a[i];
                m_sel[i] = 0; m_en[i] = 1; m_enp[i] = 1;
                m_mode[i] = 0; m_slew[i] = 0; m_sc[i] = 0;
            end
            m_pre = 0;
            m_anyp = 0;
        end else begin
            tick = (m_pre == DIV - 1);
            for (int i = 0; i < N; i++) begin
                lim = 8 >> m_slew[i];
                t = m_tgt(i);
                nc[i] = m_code[i];
                ns[i] = m_sc[i];
                jump = m_slw(i) && m_code[i] > t && t < FLOOR && m_code[i] <= FLOOR;
                if (m_en[i] != 0 && m_enp[i] == 0) nc[i] = t;
                else if (jump) nc[i] = t;
                else if (m_slw(i) && tick && m_sc[i] == lim - 1)
                    nc[i] = (m_code[i] > t) ? m_code[i] - 1 : m_code[i] + 1;
                if (!m_slw(i) || jump) ns[i] = 0;
                else if (tick) ns[i] = (m_sc[i] == lim - 1) ? 0 : m_sc[i] + 1;
            end
            m_anyp = m_any();
            for (int i = 0; i < N; i++) begin
                m_enp[i] = m_en[i];
                m_code[i] = nc[i];
                m_sc[i] = ns[i];
            end
            if (wr_en) begin
                a = int'(wr_addr);
                if (a < N) m_a[a] = int'(wr_data);
                else if (a < 2*N) m_b[a-N] = int'(wr_data);
                else if (a == 2*N) for (int i = 0; i < N; i++) m_sel[i] = int'(wr_data[i]);
                else if (a == 2*N+1) for (int i = 0; i < N; i++) m_en[i] = int'(wr_data[i]);
                else if (a < 3*N+2) begin
                    m_mode[a-2*N-2] = int'(wr_data[1:0]);
                    m_slew[a-2*N-2] = int'(wr_data[3:2]);
                end
            end
            m_pre = tick ? 0 : m_pre + 1;
        end
    end

    // per-cycle comparison, away from both edges of stimulus
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            for (int i = 0; i < N; i++) begin
                check("R2", $sformatf("code ch%0d", i), code_of(i), m_code[i]);
                check("R8", $sformatf("pfm ch%0d", i), int'(pfm_req[i]),
                      int'(m_code[i] < FLOOR || m_mode[i] == 2 ||
                           ((m_mode[i] == 0 || m_mode[i] == 3) && !load_hi[i])));
            end
            check("R6", "slewing", int'(slewing), int'(m_any()));
            check("R6", "all_ready", int'(all_ready), int'(m_anyp && !m_any()));
            if (all_ready) rdy_cnt++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(int a, int d);
        wr_en = 1'b1;
        wr_addr = AW'(a);
        wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle_wait();
        int n = 0;
        while (slewing && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic step_gap(int ch, int exp, string req);
        int v = code_of(ch);
        int n = 0;
        while (code_of(ch) == v && n < 1000) begin @(negedge clk); n++; end
        v = code_of(ch);
        n = 0;
        while (code_of(ch) == v && n < 1000) begin @(negedge clk); n++; end
        check(req, $sformatf("step gap ch%0d", ch), n, exp);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (all requirements) actual=200000 expected=<200000");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        int r0;
        int prev;
        bit seen;
        int at;
        int mx;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int i = 0; i < N; i++)
            check("R1", $sformatf("reset code ch%0d", i), code_of(i), int'(DEFS[i*8 +: 8]));
        check("R1", "reset slewing", int'(slewing), 0);
        check("R1", "reset all_ready", int'(all_ready), 0);
        check("R1", "reset pfm", int'(pfm_req), 0);

        // R4 / R3 fastest rate: ch0 ctl slew 11
        wr(10, 8'h0C);
        r0 = rdy_cnt;
        wr(0, 105);
        check("R4", "slewing after selected write", int'(slewing), 1);
        step_gap(0, DIV, "R3");
        idle_wait();
        check("R4", "ch0 final", code_of(0), 105);
        @(negedge clk);
        check("R6", "one ready event", rdy_cnt, r0 + 1);

        // R3 slowest rate
        wr(10, 8'h00);
        wr(0, 100);
        step_gap(0, 8 * DIV, "R3");
        idle_wait();
        check("R2", "ch0 back", code_of(0), 100);

        // R5 unselected write is held
        wr(11, 8'h0C);
        wr(5, 60);
        repeat (10) @(negedge clk);
        check("R5", "ch1 held", code_of(1), 90);
        check("R5", "no slewing", int'(slewing), 0);
        wr(6, 85);
        wr(12, 8'h0C);
        r0 = rdy_cnt;
        wr(8, 8'h06);
        check("R5", "select starts ramp", int'(slewing), 1);
        prev = code_of(1);
        seen = 0;
        while (slewing) begin
            @(negedge clk);
            if (code_of(1) == 60 && !seen) begin
                seen = 1;
                check("R7", "code before floor jump", prev, FLOOR);
            end
            prev = code_of(1);
        end
        check("R7", "jump seen", int'(seen), 1);
        check("R7", "ch1 final", code_of(1), 60);
        check("R5", "ch2 final", code_of(2), 85);
        check("R8", "pfm below floor", int'(pfm_req[1]), 1);
        @(negedge clk);
        check("R6", "single ready for joint ramp", rdy_cnt, r0 + 1);

        // R8 mode field on ch3
        wr(13, 8'h01);
        load_hi[3] = 1'b0;
        @(negedge clk);
        check("R8", "forced pwm", int'(pfm_req[3]), 0);
        wr(13, 8'h02);
        check("R8", "forced pfm", int'(pfm_req[3]), 1);
        wr(13, 8'h00);
        check("R8", "auto light load", int'(pfm_req[3]), 1);
        load_hi[3] = 1'b1;
        @(negedge clk);
        check("R8", "auto heavy load", int'(pfm_req[3]), 0);
        load_hi[3] = 1'b0;
        wr(13, 8'h03);
        check("R8", "auto alt light load", int'(pfm_req[3]), 1);
        load_hi[3] = 1'b1;

        // R9 disable / enable
        wr(9, 8'h0E);
        wr(0, 50);
        repeat (10) @(negedge clk);
        check("R9", "disabled holds", code_of(0), 100);
        check("R9", "disabled no slewing", int'(slewing), 0);
        wr(9, 8'h0F);
        check("R9", "enable no slewing", int'(slewing), 0);
        @(negedge clk);
        check("R9", "enable loads target", code_of(0), 50);
        check("R9", "enable no ramp", int'(slewing), 0);
        check("R8", "pfm after direct load", int'(pfm_req[0]), 1);

        // R10 re-aim mid ramp
        wr(13, 8'h0D);
        wr(3, 140);
        while (code_of(3) < 130) @(negedge clk);
        at = code_of(3);
        wr(3, 125);
        mx = code_of(3);
        while (slewing) begin
            @(negedge clk);
            if (code_of(3) > mx) mx = code_of(3);
        end
        check("R10", "no overshoot after re-aim", int'(mx <= at + 1), 1);
        check("R10", "ch3 final", code_of(3), 125);

        // R5 select back to A on two channels
        wr(8, 8'h00);
        idle_wait();
        check("R5", "ch1 back to A", code_of(1), 90);
        check("R5", "ch2 back to A", code_of(2), 80);
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule